// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block takes the four shared PCI interrupt request lines of a bus segment and steers each one onto one of sixteen legacy interrupt-controller inputs. Each request line has its own one-byte steering register. Software sets these registers over a simple byte-wide configuration write port and can read them back. A steering value below sixteen names the controller input the line drives. Any larger value switches the line off.

Several request lines may be steered to the same controller input, and they then combine as a level OR. The block keeps a registered map of which request line is driving which controller input. This map is rebuilt on every clock from the live request levels and the steering values. The new values include any write made in that same cycle. As a result, a line moved to a new input stops driving its old input in the same update that starts driving the new one.

Two combinational helpers come with the router. The first is a route query per request line, which reports whether the line is enabled and which input it drives. The second is a swizzle that turns a device slot number and an INTx pin into the request-line index that the device's pin is wired to.

Top module: `pirq_router`

## Requirements
- R1: While reset is high and in the first cycle after it, `irq_out` is all zero. Every steering byte reads 0x80 and every `route_en` bit is 0.
- R2: The steering byte for request line i (i = 0..3) lives at configuration address 0x60 + i. A write there stores `cfg_wdata` unchanged, and a read of that address returns the stored byte. Without a write, the steering state stays the same.
- R3: With a steering byte v < 16 and `pirq_lvl[i]` high in cycle t, `irq_out[v]` is 1 in cycle t+1. With the line low and no other source on v, `irq_out[v]` is 0 in cycle t+1.
- R4: A steering byte of 16 or more disables its line. Level changes on a disabled line leave every bit of `irq_out` unchanged.
- R5: Each `irq_out` bit is the OR of the levels of all enabled lines steered to it. No bit is set unless some enabled line steered there is high, so at most as many bits are set as there are enabled high lines.
- R6: After a steering byte is rewritten, the next update drives only the new target. The old target is released in that same cycle unless another line still drives it.
- R7: A steering write and a request-level change in the same cycle both show in the `irq_out` value of the following cycle.
- R8: `swz_pirq` equals (`swz_pin` + `swz_slot` − 1) mod 4. Here `swz_pin` 0 is INTA and `swz_slot` is the 5-bit device number.
- R9: For each line i, `route_en[i]` is 1 exactly when its steering byte is below 16. `route_line[4*i+3:4*i]` then holds the byte's value; when the line is disabled this field is 0.
- R10: Writes to addresses outside 0x60..0x63 change no steering byte and no output. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pirq_lvl | input | 4 | Live levels of request lines 0..3 |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte address (read and write) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` (combinational) |
| irq_out | output | 16 | Registered controller input levels |
| route_en | output | 4 | Route query: line i enabled |
| route_line | output | 16 | Route query: 4-bit target input per line, line i at bits 4i+3..4i |
| swz_slot | input | 5 | Device slot number for the swizzle |
| swz_pin | input | 2 | INTx pin for the swizzle (0 = INTA) |
| swz_pirq | output | 2 | Request-line index from the swizzle |

## Verification
The router is exercised with four kinds of pattern:
- Every line disabled while the levels toggle. This separates a correct enable decode from one that leaks disabled lines.
- Distinct targets per line with walking level patterns. This shows whether each line lands on its own input.
- Two lines sharing one input. This tells a level OR apart from a last-writer or single-source mapping.
- Rewrites while lines are held high, including a rewrite in the same cycle as a level change. These expose a map that keeps stale bits or that misses either event.

The swizzle is checked over every slot and pin combination, and writes to neighbouring addresses show that decoding is exact.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

    localparam int NUM_PIRQ    = 4;
    localparam int NUM_LINES   = 16;
    localparam int LINE_W      = $clog2(NUM_LINES);
    localparam int PIRQ_W      = $clog2(NUM_PIRQ);
    localparam int CFG_AW      = 8;
    localparam int CFG_DW      = 8;
    localparam int SLOT_W      = 5;
    localparam logic [CFG_AW-1:0] ROUTE_BASE  = 8'h60;
    localparam logic [CFG_DW-1:0] ROUTE_RESET = 8'h80;

    typedef struct packed {
        logic              en;
        logic [LINE_W-1:0] line;
    } route_t;

    // Steering byte to route: enabled only when every bit above the line field is clear.
    function automatic route_t decode_route(input logic [CFG_DW-1:0] b);
        route_t r;
        r.en   = (b[CFG_DW-1:LINE_W] == '0);
        r.line = r.en ? b[LINE_W-1:0] : '0;
        return r;
    endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_router_pkg::*;
#(
    parameter int NP = NUM_PIRQ
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [CFG_AW-1:0]      addr,
    input  logic [CFG_DW-1:0]      wdata,
    output logic [CFG_DW-1:0]      rdata,
    output route_t [NP-1:0]        route_cur,
    output route_t [NP-1:0]        route_nxt
);

    logic [NP-1:0][CFG_DW-1:0] steer_q;
    logic [NP-1:0][CFG_DW-1:0] steer_d;
    logic [NP-1:0]             addr_hit;

    for (genvar i = 0; i < NP; i++) begin : g_steer
        assign addr_hit[i]  = (addr == CFG_AW'(ROUTE_BASE + CFG_AW'(i)));
        assign steer_d[i]   = (wr_en && addr_hit[i]) ? wdata : steer_q[i];
        assign route_cur[i] = decode_route(steer_q[i]);
        assign route_nxt[i] = decode_route(steer_d[i]);

        always_ff @(posedge clk) begin
            if (rst) steer_q[i] <= ROUTE_RESET;
            else     steer_q[i] <= steer_d[i];
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NP; i++) begin
            if (addr_hit[i]) rdata = steer_q[i];
        end
    end

endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
    import pirq_router_pkg::*;
#(
    parameter int NP = NUM_PIRQ,
    parameter int NL = NUM_LINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NP-1:0]     lvl,
    input  route_t [NP-1:0]   routes,
    output logic [NL-1:0]     lines
);

    logic [NL-1:0][NP-1:0] map_q;
    logic [NL-1:0][NP-1:0] map_d;

    for (genvar l = 0; l < NL; l++) begin : g_line
        for (genvar p = 0; p < NP; p++) begin : g_src
            assign map_d[l][p] = routes[p].en && (routes[p].line == LINE_W'(l)) && lvl[p];
        end
        assign lines[l] = |map_q[l];
    end

    // Whole map rebuilt each cycle, so a re-steered line never leaves a stale bit.
    always_ff @(posedge clk) begin
        if (rst) map_q <= '0;
        else     map_q <= map_d;
    end

endmodule

// File: rtl/pirq_slot_swizzle.sv
module pirq_slot_swizzle
    import pirq_router_pkg::*;
(
    input  logic [SLOT_W-1:0] slot,
    input  logic [PIRQ_W-1:0] pin,
    output logic [PIRQ_W-1:0] pirq
);

    logic [PIRQ_W-1:0] slot_low;

    assign slot_low = slot[PIRQ_W-1:0];
    assign pirq     = pin + slot_low - PIRQ_W'(1);

endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_router_pkg::*;
#(
    parameter int NP = NUM_PIRQ,
    parameter int NL = NUM_LINES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NP-1:0]        pirq_lvl,
    input  logic                 cfg_wr_en,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [CFG_DW-1:0]    cfg_wdata,
    output logic [CFG_DW-1:0]    cfg_rdata,
    output logic [NL-1:0]        irq_out,
    output logic [NP-1:0]        route_en,
    output logic [NP*LINE_W-1:0] route_line,
    input  logic [SLOT_W-1:0]    swz_slot,
    input  logic [PIRQ_W-1:0]    swz_pin,
    output logic [PIRQ_W-1:0]    swz_pirq
);

    route_t [NP-1:0] route_cur;
    route_t [NP-1:0] route_nxt;

    pirq_route_regs #(.NP(NP)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_wr_en),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .route_cur (route_cur),
        .route_nxt (route_nxt)
    );

    pirq_level_map #(.NP(NP), .NL(NL)) u_map (
        .clk    (clk),
        .rst    (rst),
        .lvl    (pirq_lvl),
        .routes (route_nxt),
        .lines  (irq_out)
    );

    pirq_slot_swizzle u_swz (
        .slot (swz_slot),
        .pin  (swz_pin),
        .pirq (swz_pirq)
    );

    for (genvar i = 0; i < NP; i++) begin : g_query
        assign route_en[i]                     = route_cur[i].en;
        assign route_line[i*LINE_W +: LINE_W]  = route_cur[i].line;
    end

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
    import pirq_router_pkg::*;
#(
    parameter int NP = NUM_PIRQ,
    parameter int NL = NUM_LINES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NP-1:0]        pirq_lvl,
    input  logic                 cfg_wr_en,
    input  logic [NL-1:0]        irq_out,
    input  logic [NP-1:0]        route_en,
    input  logic [NP*LINE_W-1:0] route_line
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (irq_out == '0));

    assert_route_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr_en |=> ($stable(route_en) && $stable(route_line)));

    assert_disabled_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr_en && route_en == '0) |=> (irq_out == '0));

    assert_no_spurious_line_R5: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr_en |=> ($countones(irq_out) <= $past($countones(pirq_lvl & route_en))));

    for (genvar gi = 0; gi < NP; gi++) begin : g_steer_chk
        assert_steer_hits_line_R3: assert property (@(posedge clk) disable iff (rst)
            (route_en[gi] && pirq_lvl[gi] && !cfg_wr_en)
            |=> irq_out[$past(route_line[gi*LINE_W +: LINE_W])]);
    end

endmodule

bind pirq_router pirq_router_chk #(.NP(NP), .NL(NL)) u_chk (.*);

// File: tb/pirq_router_tb_top.sv
module pirq_router_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  pirq_lvl;
    logic        cfg_wr_en;
    logic [7:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic [15:0] irq_out;
    logic [3:0]  route_en;
    logic [15:0] route_line;
    logic [4:0]  swz_slot;
    logic [1:0]  swz_pin;
    logic [1:0]  swz_pirq;

    always #5 clk = ~clk;

    pirq_router dut_i (
        .clk(clk), .rst(rst), .pirq_lvl(pirq_lvl),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_out(irq_out),
        .route_en(route_en), .route_line(route_line),
        .swz_slot(swz_slot), .swz_pin(swz_pin), .swz_pirq(swz_pirq)
    );

    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 0;
    int          steer [4];
    logic [15:0] exp_irq;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_lines();
        logic [15:0] r = '0;
        for (int p = 0; p < 4; p++)
            if (steer[p] < 16 && pirq_lvl[p]) r[steer[p]] = 1'b1;
        return r;
    endfunction

    // One clock: model follows the edge, compare at the falling edge.
    task automatic cyc(input string req);
        @(posedge clk);
        if (rst) begin
            for (int p = 0; p < 4; p++) steer[p] = 8'h80;
            exp_irq = '0;
        end else begin
            if (cfg_wr_en && cfg_addr >= 8'h60 && cfg_addr <= 8'h63)
                steer[cfg_addr - 8'h60] = int'(cfg_wdata);
            exp_irq = model_lines();
        end
        @(negedge clk);
        chk(req, 32'(irq_out), 32'(exp_irq));
        cfg_wr_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        cyc(req);
    endtask

    task automatic check_query(input string req);
        for (int p = 0; p < 4; p++) begin
            cfg_addr = 8'(8'h60 + p);
            #1;
            chk("R2 readback", 32'(cfg_rdata), 32'(steer[p]));
            chk(req, 32'(route_en[p]), 32'(steer[p] < 16));
            chk(req, 32'(route_line[p*4 +: 4]), (steer[p] < 16) ? 32'(steer[p]) : 32'd0);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pirq_lvl = '0; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        swz_slot = '0; swz_pin = '0;
        @(negedge clk);
        pirq_lvl = 4'hF;
        for (int k = 0; k < 3; k++) cyc("R1 in reset");
        rst = 1'b0;
        cyc("R1 first cycle");
        check_query("R1 reset route");

        // R4: all disabled, toggle levels
        for (int k = 0; k < 6; k++) begin pirq_lvl = 4'(k * 5); cyc("R4 disabled"); end

        // R2 / R3: distinct targets
        wr(8'h60, 8'd3,  "R2 write");
        wr(8'h61, 8'd7,  "R2 write");
        wr(8'h62, 8'd15, "R2 write");
        wr(8'h63, 8'h10, "R4 value 16");
        check_query("R9 query");
        for (int k = 0; k < 16; k++) begin pirq_lvl = 4'(k); cyc("R3 steer"); end
        pirq_lvl = 4'b1000; cyc("R4 line3 off");

        // R5: sharing
        wr(8'h60, 8'd5, "R5 setup");
        wr(8'h61, 8'd5, "R5 setup");
        for (int k = 0; k < 4; k++) begin pirq_lvl = 4'(k); cyc("R5 shared OR"); end

        // R6: move while high
        pirq_lvl = 4'b0001; cyc("R6 pre");
        wr(8'h60, 8'd9, "R6 move");
        chk("R6 old released", 32'(irq_out[5]), 32'd0);
        chk("R6 new driven", 32'(irq_out[9]), 32'd1);
        pirq_lvl = 4'b0011;
        wr(8'h61, 8'd9, "R6 join");
        wr(8'h60, 8'd2, "R6 leave shared");
        chk("R6 shared kept", 32'(irq_out[9]), 32'd1);

        // R7: write and level change together
        pirq_lvl = 4'b0100;
        wr(8'h62, 8'd0, "R7 simultaneous");
        chk("R7 both seen", 32'(irq_out), 32'h0001);

        // R10: neighbouring addresses
        wr(8'h64, 8'd1, "R10 write 0x64");
        wr(8'h5F, 8'd1, "R10 write 0x5F");
        check_query("R10 unchanged");
        cfg_addr = 8'h64; #1;
        chk("R10 read 0x64", 32'(cfg_rdata), 32'd0);
        cfg_addr = 8'h00; #1;
        chk("R10 read 0x00", 32'(cfg_rdata), 32'd0);

        // R4: disable at runtime then toggle
        wr(8'h62, 8'hFF, "R4 disable");
        for (int k = 0; k < 4; k++) begin pirq_lvl = {1'b0, k[0], 2'b00}; cyc("R4 toggle disabled"); end
        check_query("R9 after disable");

        // R8: swizzle
        for (int s = 0; s < 32; s++) begin
            for (int p = 0; p < 4; p++) begin
                swz_slot = 5'(s); swz_pin = 2'(p); #1;
                chk("R8 swizzle", 32'(swz_pirq), 32'((p + s - 1) & 3));
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule